// File: doc/BRIEF.md
# Segmented Transmit Bus Protocol Monitor

This block sits beside a wide transmit bus that carries several fixed-size segments in every clock cycle, and watches it without driving anything. Each segment has an active flag, a start-of-packet flag, an end-of-packet flag and an empty-byte count. The monitor also watches the ready signal that the receiving side returns. It replays the protocol rules for every segment, from segment 0 up to the last one. It remembers across cycles whether a packet is open and how many bytes that packet has carried so far.

Five classes of rule break are reported. Each class has a one-cycle error pulse and a sticky bit. The sticky bits accumulate until software-side logic pulses the clear input. The monitor is meant for simulation and for on-chip debug of a transmit path. The ready timing it checks lets a writer finish the beat in the first cycle after ready falls, but not after that.

Top module: `segbus_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, every error pulse and every sticky bit reads 0.
- R2: The error bit positions are 0 framing, 1 gap, 2 empty-count, 3 undersize and 4 overflow. A pulse appears on the clock edge that samples the offending cycle and stays high for that one cycle only. Several classes may pulse together.
- R3: Framing error: a segment with the start flag arrives while a packet is open, or an active segment without the start flag arrives while no packet is open. Segments are evaluated in order 0 to 3, and the open state carries over to the next cycle.
- R4: An end-of-packet segment directly followed by a start-of-packet segment raises no error. This holds inside one cycle and also from segment 3 to segment 0 of the next cycle.
- R5: Empty-count error: an active segment without the end flag carries a nonzero empty count. On an end segment the count (bits [4i+3:4i] for segment i) removes 1 to 15 bytes from the 16, and 0 means all 16 bytes are valid.
- R6: Undersize error: at its end segment, a packet has carried fewer than 64 bytes in total, counted from its most recent start segment. Exactly 64 bytes is legal.
- R7: Gap error: an inactive segment appears while a packet is open and ready is high. When ready is low, idle segments inside a packet are legal.
- R8: Overflow error: any segment is active in a cycle where ready is low and ready was also low in the previous cycle. A write in the first low cycle is legal, and ready is taken as high before the first cycle after reset.
- R9: Sticky bits OR in every pulse. In a cycle whose clear input is high, the sticky register is loaded with that cycle's pulses instead, so an error seen during a clear is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| segEna | input | NUM_SEG | Per-segment active flag |
| segSop | input | NUM_SEG | Per-segment start-of-packet flag |
| segEop | input | NUM_SEG | Per-segment end-of-packet flag |
| segMty | input | NUM_SEG*log2(SEG_BYTES) | Per-segment empty-byte count, segment i in field i |
| busReady | input | 1 | Ready returned by the receiving side, same cycle as the data |
| stickyClr | input | 1 | Clears the sticky error register |
| errPulse | output | 5 | One-cycle error pulse per class |
| errSticky | output | 5 | Accumulated error classes |

## Verification
The bench builds the monitor with its defaults: four segments of 16 bytes and a 64-byte minimum. With these values a minimum-size packet fits exactly into one cycle, so an empty count of 1 on the last segment crosses the undersize boundary. A packet that starts on segment 0 can end on segment 3 and be followed by a new start on segment 0 of the next cycle. The default sizes also let packets span cycles, restart on a misplaced start flag, and meet several error classes in a single cycle.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
  localparam int ERR_N = 5;

  // Field order sets bit positions: frm is bit 0, ovf is bit 4.
  typedef struct packed {
    logic ovf;
    logic und;
    logic mty;
    logic gap;
    logic frm;
  } errStrobes_t;
endpackage

// File: rtl/segbus_ctrl.sv
module segbus_ctrl
  import segbus_pkg::*;
#(
  parameter int NUM_SEG   = 4,
  parameter int SEG_BYTES = 16,
  parameter int MIN_PKT   = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SEG-1:0]                segEna,
  input  logic [NUM_SEG-1:0]                segSop,
  input  logic [NUM_SEG-1:0]                segEop,
  input  logic [NUM_SEG*$clog2(SEG_BYTES)-1:0] segMty,
  input  logic                              busReady,
  output errStrobes_t                       strobes
);
  localparam int MTY_W = $clog2(SEG_BYTES);
  localparam int CNT_W = $clog2(MIN_PKT + SEG_BYTES + 1);
  localparam logic [CNT_W-1:0] SEG_C = CNT_W'(SEG_BYTES);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PKT);

  logic             openQ, openV;
  logic [CNT_W-1:0] cntQ, cntV, addV, sumV;
  logic [MTY_W-1:0] mtyS;
  logic             readyPrevQ;
  logic             frmV, gapV, mtyV, undV, ovfV;

  // Walk the segments in bus order; each one sees the state left by the one before.
  always_comb begin
    openV = openQ;
    cntV  = cntQ;
    frmV  = 1'b0;
    gapV  = 1'b0;
    mtyV  = 1'b0;
    undV  = 1'b0;
    addV  = '0;
    sumV  = '0;
    mtyS  = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      mtyS = segMty[s*MTY_W +: MTY_W];
      if (!segEna[s]) begin
        if (openV && busReady) gapV = 1'b1;
      end else begin
        if ((mtyS != '0) && !segEop[s]) mtyV = 1'b1;
        if (segSop[s]) begin
          if (openV) frmV = 1'b1;
          openV = 1'b1;
          cntV  = '0;
        end else if (!openV) begin
          frmV = 1'b1;
        end
        if (openV) begin
          addV = segEop[s] ? (SEG_C - {{(CNT_W-MTY_W){1'b0}}, mtyS}) : SEG_C;
          sumV = cntV + addV;
          cntV = (sumV > MIN_C) ? MIN_C : sumV;
          if (segEop[s]) begin
            if (cntV < MIN_C) undV = 1'b1;
            openV = 1'b0;
          end
        end
      end
    end
    ovfV = (|segEna) && !busReady && !readyPrevQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ      <= 1'b0;
      cntQ       <= '0;
      readyPrevQ <= 1'b1;
    end else begin
      openQ      <= openV;
      cntQ       <= cntV;
      readyPrevQ <= busReady;
    end
  end

  always_comb begin
    strobes     = '0;
    strobes.frm = frmV;
    strobes.gap = gapV;
    strobes.mty = mtyV;
    strobes.und = undV;
    strobes.ovf = ovfV;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!busReady) && !busReady && (|segEna)) |-> strobes.ovf);

  // R8
  ready_high_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> !strobes.ovf);

  // R7
  gap_ready_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> !strobes.gap);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|segEna) |-> !(strobes.frm || strobes.mty || strobes.und || strobes.ovf));
endmodule

// File: rtl/segbus_datapath.sv
module segbus_datapath
  import segbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  errStrobes_t      strobes,
  input  logic             stickyClr,
  output logic [ERR_N-1:0] errPulse,
  output logic [ERR_N-1:0] errSticky
);
  logic [ERR_N-1:0] strobeVec;
  assign strobeVec = strobes;

  for (genvar k = 0; k < ERR_N; k++) begin : g_cls
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errPulse[k]  <= 1'b0;
        errSticky[k] <= 1'b0;
      end else begin
        errPulse[k]  <= strobeVec[k];
        errSticky[k] <= (stickyClr ? 1'b0 : errSticky[k]) | strobeVec[k];
      end
    end
  end

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyClr |=> (errSticky == errPulse));

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stickyClr |=> ((errSticky & $past(errSticky)) == $past(errSticky)));

  // R9
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((errSticky & errPulse) == errPulse));
endmodule

// File: rtl/segbus_monitor.sv
module segbus_monitor
  import segbus_pkg::*;
#(
  parameter int NUM_SEG   = 4,
  parameter int SEG_BYTES = 16,
  parameter int MIN_PKT   = 64
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_SEG-1:0]                   segEna,
  input  logic [NUM_SEG-1:0]                   segSop,
  input  logic [NUM_SEG-1:0]                   segEop,
  input  logic [NUM_SEG*$clog2(SEG_BYTES)-1:0] segMty,
  input  logic                                 busReady,
  input  logic                                 stickyClr,
  output logic [ERR_N-1:0]                     errPulse,
  output logic [ERR_N-1:0]                     errSticky
);
  errStrobes_t strobes;

  segbus_ctrl #(
    .NUM_SEG  (NUM_SEG),
    .SEG_BYTES(SEG_BYTES),
    .MIN_PKT  (MIN_PKT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .segEna  (segEna),
    .segSop  (segSop),
    .segEop  (segEop),
    .segMty  (segMty),
    .busReady(busReady),
    .strobes (strobes)
  );

  segbus_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stickyClr(stickyClr),
    .errPulse (errPulse),
    .errSticky(errSticky)
  );
endmodule

// File: tb/sim_segbus_monitor.sv
module sim_segbus_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  segEna = '0, segSop = '0, segEop = '0;
  logic [15:0] segMty = '0;
  logic        busReady = 1'b1;
  logic        stickyClr = 1'b0;
  logic [4:0]  errPulse, errSticky;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] expQ[$];
  logic       clrQ[$];
  string      tagQ[$];
  logic [4:0] expStk = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segbus_monitor u0 (
    .clk(clk), .rstN(rstN), .segEna(segEna), .segSop(segSop), .segEop(segEop),
    .segMty(segMty), .busReady(busReady), .stickyClr(stickyClr),
    .errPulse(errPulse), .errSticky(errSticky)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: apply one bus cycle and queue the expected pulse vector.
  task automatic cyc(input logic [3:0] ena, input logic [3:0] sop, input logic [3:0] eop,
                     input logic [15:0] mty, input logic rdy, input logic clr,
                     input logic [4:0] exp, input string tag);
    @(negedge clk);
    segEna = ena; segSop = sop; segEop = eop; segMty = mty;
    busReady = rdy; stickyClr = clr;
    expQ.push_back(exp); clrQ.push_back(clr); tagQ.push_back(tag);
  endtask

  // Monitor: compare after each edge that sampled a queued cycle.
  always begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      logic [4:0] e;
      logic       c;
      string      t;
      e = expQ.pop_front(); c = clrQ.pop_front(); t = tagQ.pop_front();
      expStk = c ? e : (expStk | e);
      check({t, " pulse"}, errPulse, e);
      check({t, " sticky R9"}, errSticky, expStk);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pulse", errPulse, 5'b0);
    check("R1 reset sticky", errSticky, 5'b0);
    rstN = 1'b1;
    // R7 idle with nothing open
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 1, 0, 5'b00000, "R1 R7 idle closed");
    // R6 exact 64 bytes
    cyc(4'hF, 4'h1, 4'h8, 16'h0, 1, 0, 5'b00000, "R6 64B");
    // R6 R5 63 bytes via empty count on end segment
    cyc(4'hF, 4'h1, 4'h8, 16'h1000, 1, 0, 5'b01000, "R6 63B undersize");
    // R4 multi-cycle, end then start in same cycle
    cyc(4'hF, 4'h1, 4'h0, 16'h0, 1, 0, 5'b00000, "R6 open 64");
    cyc(4'hF, 4'h4, 4'h2, 16'h0, 1, 0, 5'b00000, "R4 eop seg1 sop seg2");
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 0, 0, 5'b00000, "R7 idle mid-packet ready low");
    cyc(4'hF, 4'h0, 4'h8, 16'hF000, 1, 0, 5'b00000, "R5 eop empty 15 81B");
    // R4 segment 3 end then segment 0 start next cycle
    cyc(4'hF, 4'h1, 4'h0, 16'h0, 1, 0, 5'b00000, "R4 open");
    cyc(4'hF, 4'h0, 4'h8, 16'h0, 1, 0, 5'b00000, "R4 eop seg3");
    cyc(4'hF, 4'h1, 4'h8, 16'h0, 1, 0, 5'b00000, "R4 sop seg0 next");
    // R7 gap with ready high
    cyc(4'hF, 4'h1, 4'h0, 16'h0, 1, 0, 5'b00000, "R7 open");
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 1, 0, 5'b00010, "R7 gap ready high");
    cyc(4'h3, 4'h0, 4'h2, 16'h0, 1, 0, 5'b00000, "R7 close then idle");
    // R8 grace cycle then overflow
    cyc(4'hF, 4'h1, 4'h0, 16'h0, 0, 0, 5'b00000, "R8 first low write");
    cyc(4'hF, 4'h0, 4'h8, 16'h0, 0, 0, 5'b10000, "R8 second low write");
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 0, 0, 5'b00000, "R8 low no write");
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 1, 0, 5'b00000, "R8 ready back");
    // R3 framing
    cyc(4'h1, 4'h0, 4'h0, 16'h0, 1, 0, 5'b00001, "R3 data no packet");
    cyc(4'hF, 4'h1, 4'h0, 16'h0, 1, 0, 5'b00000, "R3 open");
    cyc(4'hF, 4'h4, 4'h0, 16'h0, 1, 0, 5'b00001, "R3 sop while open");
    cyc(4'hF, 4'h0, 4'h8, 16'h0, 1, 0, 5'b00000, "R3 restart 96B");
    // R5 empty count on non-end segment
    cyc(4'hF, 4'h1, 4'h8, 16'h0050, 1, 0, 5'b00100, "R5 empty on data seg");
    // R6 start and end in one segment
    cyc(4'h1, 4'h1, 4'h1, 16'h0, 1, 0, 5'b01000, "R6 16B packet");
    // R9 clear with simultaneous error, then plain clear
    cyc(4'h1, 4'h0, 4'h0, 16'h0, 1, 1, 5'b00001, "R9 clear with error");
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 1, 1, 5'b00000, "R9 clear");
    // R2 several classes together, then pulse drops
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 0, 0, 5'b00000, "R2 low idle");
    cyc(4'h1, 4'h0, 4'h0, 16'h0, 0, 0, 5'b10001, "R2 framing plus overflow");
    cyc(4'h0, 4'h0, 4'h0, 16'h0, 1, 0, 5'b00000, "R2 pulse one cycle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule